// File: doc/BRIEF.md
# Fixed-Window Instruction Memory

This block stands where an instruction cache would sit, but it holds no tags and never refills. A local RAM is mapped at a fixed, size-aligned address window. Whether a fetch hits depends only on its address: the bits above log2 of the RAM size are compared with the window base. A fetch inside the window is served from the RAM with zero wait states. A fetch outside the window is a miss. It is handed unchanged to the external bus path, and the fetch port stalls until that path returns the word.

The RAM is loaded through a one-word-per-clock preload port. That port only takes effect while the fetch side is idle and no fetch is requested. The RAM size is a power-of-two parameter (`RAM_BYTES`). The window logic works for any size, including 512 KB and larger. The block assumes there is no address translation in front of it.

The controller has three states. IDLE accepts fetches and preload writes. FWD drives the bus request and waits for its acknowledge. RET hands the bus word to the CPU for one cycle.

The transitions are:
- IDLE→IDLE on an in-window fetch or no fetch.
- IDLE→FWD on an out-of-window fetch.
- FWD→FWD while there is no bus acknowledge.
- FWD→RET on a bus acknowledge.
- RET→IDLE unconditionally.

Top module: `fixed_window_imem`

## Requirements
- R1: While reset is held, `fetch_ack` and `bus_req` are 0 and `fetch_ready` is 1.
- R2: `fetch_hit` is 1 exactly when `fetch_addr[ADDR_W-1:log2(RAM_BYTES)]` equals the same bits of `WIN_BASE`. No other state influences it.
- R3: A fetch accepted with `fetch_hit`=1 gives `fetch_ack`=1 on the next cycle, carrying the RAM word at index `fetch_addr[log2(RAM_BYTES)-1:2]`. In-window fetches can be accepted on every cycle.
- R4: An accepted in-window fetch never raises `bus_req`.
- R5: An accepted out-of-window fetch raises `bus_req` on the next cycle, with `bus_addr` equal to the fetch address. Both are held stable until `bus_ack`.
- R6: While `bus_req` is 1, `fetch_ready` is 0. In the cycle after `bus_ack`, `fetch_ack`=1 and `fetch_rdata` equals the `bus_rdata` sampled with that acknowledge. `fetch_ready` returns to 1 one cycle later.
- R7: A word returned for a miss is never written into the RAM, even when its low address bits alias a RAM index.
- R8: `pl_we`=1 with `fetch_req`=0 in the IDLE state writes `pl_wdata` to RAM index `pl_idx` at that clock edge.
- R9: A preload write is ignored when `fetch_req` is 1 or when the controller is in FWD or RET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | CPU fetch request |
| fetch_addr | input | ADDR_W | CPU fetch byte address |
| fetch_ready | output | 1 | Fetch accepted this cycle if requested |
| fetch_hit | output | 1 | Address lies in the RAM window |
| fetch_ack | output | 1 | Fetch data valid |
| fetch_rdata | output | DATA_W | Fetch data |
| bus_req | output | 1 | Forwarded miss request |
| bus_addr | output | ADDR_W | Forwarded miss address |
| bus_ack | input | 1 | Bus word returned |
| bus_rdata | input | DATA_W | Bus word |
| pl_we | input | 1 | Preload write strobe |
| pl_idx | input | log2(RAM_BYTES)-2 | Preload word index |
| pl_wdata | input | DATA_W | Preload word |

## Verification
The bound properties check the protocol on every cycle:
- the one-cycle hit acknowledge;
- the absence of bus traffic on a hit;
- the forwarding of the address on a miss;
- the hold of the request and its address while waiting;
- the stall while the bus is busy;
- the cycle in which the bus word comes back.

Only the bench's scenarios can show the data behaviour. This covers the RAM contents returned for hits, the window edges one word below and above the window, and that an aliasing miss leaves the RAM untouched. It also covers that preload writes made during a fetch or during a bus wait are dropped.

// File: rtl/fwi_pkg.sv
package fwi_pkg;

    // Controller states of the fetch sequencer
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // accepting fetches and preload writes
        ST_FWD  = 2'd1,   // miss forwarded, waiting for bus acknowledge
        ST_RET  = 2'd2    // returning the bus word to the CPU
    } fwi_state_e;

endpackage

// File: rtl/fwi_window_dec.sv
module fwi_window_dec #(
    parameter int unsigned       ADDR_W = 32,
    parameter int unsigned       OFF_W  = 12,
    parameter logic [ADDR_W-1:0] BASE   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win
);

    generate
        if (OFF_W >= ADDR_W) begin : g_full
            // Window covers the whole address space
            assign in_win = 1'b1;
        end else begin : g_cmp
            localparam int unsigned HI_W = ADDR_W - OFF_W;
            localparam logic [HI_W-1:0] BASE_HI = BASE[ADDR_W-1:OFF_W];
            assign in_win = (addr[ADDR_W-1:OFF_W] == BASE_HI);
        end
    endgenerate

endmodule

// File: rtl/fwi_ram.sv
module fwi_ram #(
    parameter int unsigned WORDS  = 1024,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] mem [WORDS];

    // Single-cycle synchronous read; output holds between reads
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem[rd_idx];
        end
    end

endmodule

// File: rtl/fwi_ctrl.sv
module fwi_ctrl
    import fwi_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              in_win,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              fetch_ready,
    output logic              fetch_ack,
    output logic [DATA_W-1:0] fetch_rdata,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              ram_rd_en,
    output logic              pl_allow
);

    fwi_state_e state_q, state_d;
    logic              accept;
    logic              hit_pend_q;
    logic [ADDR_W-1:0] miss_addr_q;
    logic [DATA_W-1:0] miss_data_q;

    assign accept = fetch_req && (state_q == ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !in_win) state_d = ST_FWD;
            ST_FWD:  if (bus_ack)           state_d = ST_RET;
            ST_RET:                         state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // Datapath registers for the miss path and hit acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_pend_q  <= 1'b0;
            miss_addr_q <= '0;
            miss_data_q <= '0;
        end else begin
            hit_pend_q <= accept && in_win;
            if (accept && !in_win) begin
                miss_addr_q <= fetch_addr;
            end
            if ((state_q == ST_FWD) && bus_ack) begin
                miss_data_q <= bus_rdata;
            end
        end
    end

    // Output logic
    always_comb begin
        fetch_ready = 1'b0;
        bus_req     = 1'b0;
        fetch_ack   = hit_pend_q;
        fetch_rdata = ram_rdata;
        pl_allow    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                fetch_ready = 1'b1;
                pl_allow    = !fetch_req;
            end
            ST_FWD: begin
                bus_req = 1'b1;
            end
            ST_RET: begin
                fetch_ack   = 1'b1;
                fetch_rdata = miss_data_q;
            end
            default: ;
        endcase
    end

    assign bus_addr  = miss_addr_q;
    assign ram_rd_en = accept && in_win;

endmodule

// File: rtl/fixed_window_imem.sv
module fixed_window_imem #(
    parameter int unsigned       ADDR_W    = 32,
    parameter int unsigned       DATA_W    = 32,
    parameter int unsigned       RAM_BYTES = 4096,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h0000_4000,
    localparam int unsigned      WORDS     = RAM_BYTES / 4,
    localparam int unsigned      IDX_W     = $clog2(WORDS),
    localparam int unsigned      OFF_W     = $clog2(RAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic              fetch_hit,
    output logic              fetch_ack,
    output logic [DATA_W-1:0] fetch_rdata,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              pl_we,
    input  logic [IDX_W-1:0]  pl_idx,
    input  logic [DATA_W-1:0] pl_wdata
);

    logic              in_win;
    logic              ram_rd_en;
    logic [DATA_W-1:0] ram_rdata;
    logic              pl_allow;

    fwi_window_dec #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .BASE   (WIN_BASE)
    ) u_dec (
        .addr   (fetch_addr),
        .in_win (in_win)
    );

    fwi_ram #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk     (clk),
        .rd_en   (ram_rd_en),
        .rd_idx  (fetch_addr[OFF_W-1:2]),
        .rd_data (ram_rdata),
        .wr_en   (pl_we && pl_allow),
        .wr_idx  (pl_idx),
        .wr_data (pl_wdata)
    );

    fwi_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .in_win      (in_win),
        .ram_rdata   (ram_rdata),
        .bus_ack     (bus_ack),
        .bus_rdata   (bus_rdata),
        .fetch_ready (fetch_ready),
        .fetch_ack   (fetch_ack),
        .fetch_rdata (fetch_rdata),
        .bus_req     (bus_req),
        .bus_addr    (bus_addr),
        .ram_rd_en   (ram_rd_en),
        .pl_allow    (pl_allow)
    );

    assign fetch_hit = in_win;

endmodule

// File: rtl/fwi_checker.sv
module fwi_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_ready,
    input logic              fetch_hit,
    input logic              fetch_ack,
    input logic [DATA_W-1:0] fetch_rdata,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic [DATA_W-1:0] bus_rdata
);

    // R3: accepted hit is acknowledged on the next cycle
    p_hit_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ready && fetch_hit) |=> fetch_ack);

    // R4: accepted hit produces no bus request
    p_hit_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ready && fetch_hit) |=> !bus_req);

    // R5: accepted miss forwards its address
    p_miss_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ready && !fetch_hit) |=>
            (bus_req && bus_addr == $past(fetch_addr)));

    // R5: request and address held until acknowledge
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));

    // R6: fetch port stalled while the bus is busy
    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !fetch_ready);

    // R6: bus word returned one cycle after acknowledge
    p_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=>
            (fetch_ack && !bus_req && fetch_rdata == $past(bus_rdata)));

endmodule

bind fixed_window_imem fwi_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req   (fetch_req),
    .fetch_addr  (fetch_addr),
    .fetch_ready (fetch_ready),
    .fetch_hit   (fetch_hit),
    .fetch_ack   (fetch_ack),
    .fetch_rdata (fetch_rdata),
    .bus_req     (bus_req),
    .bus_addr    (bus_addr),
    .bus_ack     (bus_ack),
    .bus_rdata   (bus_rdata)
);

// File: tb/sim_fixed_window_imem.sv
module sim_fixed_window_imem;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0000_4000;
    localparam int RAM_BYTES = 4096;
    localparam int WORDS = RAM_BYTES / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_ready, fetch_hit, fetch_ack;
    logic [31:0] fetch_rdata;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        pl_we = 1'b0;
    logic [9:0]  pl_idx = '0;
    logic [31:0] pl_wdata = '0;

    int checks = 0;
    int fails = 0;
    int lat = 0;
    bit done = 1'b0;

    logic [31:0] model [WORDS];
    logic [31:0] exp_data [$];
    bit          exp_hit [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fixed_window_imem #(
        .RAM_BYTES (RAM_BYTES),
        .WIN_BASE  (BASE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .fetch_hit(fetch_hit), .fetch_ack(fetch_ack),
        .fetch_rdata(fetch_rdata), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .pl_we(pl_we), .pl_idx(pl_idx),
        .pl_wdata(pl_wdata)
    );

    function automatic logic [31:0] bus_word(input logic [31:0] a);
        return ~a ^ 32'h3C00_00C3;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bus-side model: acknowledges after lat waiting cycles
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            bus_ack = 1'b0;
            if (bus_req) begin
                if (cnt >= lat) begin
                    bus_ack   = 1'b1;
                    bus_rdata = bus_word(bus_addr);
                    cnt = 0;
                end else begin
                    cnt++;
                end
            end
        end
    end

    // Monitor: pop the scoreboard on every acknowledge
    always @(negedge clk) begin
        if (rst_n && fetch_ack) begin
            if (exp_data.size() == 0) begin
                check(1'b0, "R3/R6 unexpected ack", fetch_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                bit h;
                e = exp_data.pop_front();
                h = exp_hit.pop_front();
                check(fetch_rdata == e, h ? "R3/R8 hit data" : "R6 miss data",
                      fetch_rdata, e);
            end
        end
    end

    // Driver: one fetch, expectation pushed at acceptance
    task automatic fetch(input logic [31:0] a);
        bit win;
        do @(negedge clk); while (!fetch_ready);
        fetch_req  = 1'b1;
        fetch_addr = a;
        win = (a[31:12] == BASE[31:12]);
        #1;
        check(fetch_hit == win, "R2 window decode", {31'b0, fetch_hit}, {31'b0, win});
        exp_hit.push_back(win);
        exp_data.push_back(win ? model[a[11:2]] : bus_word(a));
        @(posedge clk);
        #2;
        if (win) begin
            check(fetch_ack == 1'b1, "R3 zero-wait ack", {31'b0, fetch_ack}, 32'h1);
            check(bus_req == 1'b0, "R4 no bus on hit", {31'b0, bus_req}, 32'h0);
        end else begin
            check(bus_req == 1'b1 && bus_addr == a, "R5 forward addr", bus_addr, a);
            check(fetch_ready == 1'b0, "R6 stall", {31'b0, fetch_ready}, 32'h0);
        end
        fetch_req = 1'b0;
    endtask

    task automatic preload(input logic [9:0] idx, input logic [31:0] d,
                           input bit hold_req, input bit taken);
        @(negedge clk);
        pl_we    = 1'b1;
        pl_idx   = idx;
        pl_wdata = d;
        if (hold_req) begin
            fetch_req  = 1'b1;
            fetch_addr = BASE + {20'b0, idx, 2'b00};
            exp_hit.push_back(1'b1);
            exp_data.push_back(model[idx]);
        end
        @(posedge clk);
        #2;
        pl_we = 1'b0;
        fetch_req = 1'b0;
        if (taken) model[idx] = d;
    endtask

    task automatic drain();
        repeat (8) @(negedge clk);
        check(exp_data.size() == 0, "R3/R6 all responses seen",
              exp_data.size(), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(fetch_ack == 1'b0, "R1 reset ack", {31'b0, fetch_ack}, 32'h0);
        check(bus_req == 1'b0, "R1 reset bus_req", {31'b0, bus_req}, 32'h0);
        check(fetch_ready == 1'b1, "R1 reset ready", {31'b0, fetch_ready}, 32'h1);
        rst_n = 1'b1;

        // R8: preload a few words, including the last index
        for (int i = 0; i < 8; i++) preload(i[9:0], 32'hA000_0000 + i, 1'b0, 1'b1);
        preload(10'd1023, 32'hDEAD_BEEF, 1'b0, 1'b1);

        // R3: back-to-back hits, then top edge of window
        for (int i = 0; i < 8; i++) fetch(BASE + 4 * i);
        fetch(BASE + 32'd4092);
        drain();

        // R5/R6: misses just below and above the window, zero latency
        lat = 0;
        fetch(BASE - 4);
        fetch(BASE + 32'd4096);
        lat = 3;
        fetch(32'hFFFF_FFFC);
        drain();

        // R7: aliasing miss leaves RAM index 1 untouched
        fetch(32'h0000_8004);
        fetch(BASE + 4);
        drain();

        // R9: write during a fetch request, and during a bus wait
        preload(10'd2, 32'h1111_2222, 1'b1, 1'b0);
        lat = 3;
        fetch(32'h0010_0000);
        preload(10'd3, 32'h3333_4444, 1'b0, 1'b0);
        drain();
        fetch(BASE + 8);
        fetch(BASE + 12);
        drain();

        // R8: a legal overwrite after the ignored ones
        preload(10'd3, 32'h5555_6666, 1'b0, 1'b1);
        fetch(BASE + 12);
        drain();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule